// File: doc/BRIEF.md
# Bufferless OR-Merge Notification Node

This block is one router node of a small side network that tells every node which request sources have ordering work in flight during a fixed time window. Each node has four neighbour inputs and four neighbour outputs. A vector is one field per core plus a single stop bit. Contention never arises, because the node combines everything it receives with a bitwise OR and forwards the result in the same cycle. It holds no queue and never stalls, so the latency across the mesh has a fixed upper bound.

All nodes share a synchronously reset window counter, so their window boundaries line up. In the first cycle of a window the node injects its own field. That field is a saturating binary count of the requests the local sender still owes a notification for. The node also injects the stop bit when the local tracker cannot accept another vector. Through the window the node ORs every merged vector into an accumulator. In the cycle after the window closes it hands the accumulated vector to the local tracker, unless the stop bit was seen. A window carrying a stop bit is discarded everywhere, and its notifications are injected again in the next window.

The local sender keeps a pending count. The count rises when a request is accepted and falls only when a window it injected in completes without a stop. The sender refuses new requests while the count is at its limit.

Top module: `notif_node`

## Requirements
- R1: The window is WINDOW cycles long, and the first cycle after reset is cycle 0 of window 0. `win_valid` is a one-cycle pulse in the cycle after the last cycle of each window that completes without a stop, so the first possible pulse is in cycle WINDOW.
- R2: In every cycle other than the first cycle of a window, each of the four outputs equals the bitwise OR of the four neighbour inputs of the previous cycle. All four outputs always carry the same value.
- R3: A field advances one node per cycle. A field injected at window start by a node at mesh distance d appears on the outputs of the receiving node in window cycle d and not before. When WINDOW exceeds the largest distance, every node delivers an identical vector.
- R4: The local contribution appears on the outputs only in the first cycle of a window. In that cycle the outputs carry exactly the local vector, and neighbour values from the previous window are dropped.
- R5: The delivered `win_vec` is the OR of the data fields of all merged vectors over the window's cycles. Accumulation restarts empty in each window.
- R6: `req_ready` is high exactly when the pending count is below PEND_MAX. A request is accepted when `req_valid` and `req_ready` are both high; a request made while not ready is dropped.
- R7: The node's field occupies bits [NODE_ID*FIELD_W +: FIELD_W]. It carries min(pending, 2^FIELD_W-1), evaluated at the window boundary after that boundary's decrement.
- R8: The stop bit sits at bit N_CORES*FIELD_W. It is injected from `tracker_full` as sampled in the last cycle of the previous window. If any node injects it, no node pulses `win_valid` for that window, no pending count falls, and the same counts are injected in the next window.
- R9: After reset the outputs are zero, `req_ready` is high and `win_valid` is low.
- R10: When a window completes without a stop, the pending count falls by the amount that the node injected in that window. A request accepted in the same cycle is added on top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, common to all nodes |
| in_north | input | N_CORES*FIELD_W+1 | Vector from the north neighbour |
| in_east | input | N_CORES*FIELD_W+1 | Vector from the east neighbour |
| in_south | input | N_CORES*FIELD_W+1 | Vector from the south neighbour |
| in_west | input | N_CORES*FIELD_W+1 | Vector from the west neighbour |
| out_north | output | N_CORES*FIELD_W+1 | Merged vector to the north neighbour |
| out_east | output | N_CORES*FIELD_W+1 | Merged vector to the east neighbour |
| out_south | output | N_CORES*FIELD_W+1 | Merged vector to the south neighbour |
| out_west | output | N_CORES*FIELD_W+1 | Merged vector to the west neighbour |
| req_valid | input | 1 | Local request wants to enter the data network |
| req_ready | output | 1 | Pending count below its limit |
| tracker_full | input | 1 | Local tracker cannot take another vector; raises the stop bit |
| win_valid | output | 1 | Delivery strobe for a completed window |
| win_vec | output | N_CORES*FIELD_W | Accumulated per-core fields of that window |

## Verification
The bench builds 36 nodes as a 6x6 mesh. It uses 2-bit fields, a 13-cycle window and a pending limit of 4. At that size the farthest node pair is 10 hops apart, so the arrival cycle of a corner-to-corner field can be pinned inside one window. With the limit set to 4 and fields that saturate at 3, a full node must split its backlog over two windows. Random stop bits from 36 trackers make cancelled windows common enough to test resends repeatedly.

// File: rtl/notif_pkg.sv
package notif_pkg;

    typedef enum logic [1:0] {
        PH_FIRST,
        PH_MID,
        PH_LAST
    } win_phase_e;

    localparam int P_NORTH   = 0;
    localparam int P_EAST    = 1;
    localparam int P_SOUTH   = 2;
    localparam int P_WEST    = 3;
    localparam int P_LOCAL   = 4;
    localparam int NUM_PORTS = 5;

endpackage

// File: rtl/notif_window_timer.sv
module notif_window_timer
    import notif_pkg::*;
#(
    parameter int WINDOW = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    output win_phase_e phase
);
    localparam int CNT_W = (WINDOW > 2) ? $clog2(WINDOW) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.cnt == CNT_W'(WINDOW - 1)) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + CNT_W'(1);
        end
        if (tmr_q.cnt == '0) begin
            phase = PH_FIRST;
        end else if (tmr_q.cnt == CNT_W'(WINDOW - 1)) begin
            phase = PH_LAST;
        end else begin
            phase = PH_MID;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    initial begin
        assert (WINDOW >= 3) else $error("window too short");
    end

    AST_WIN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LAST) |=> (phase == PH_FIRST)); // R1

endmodule

// File: rtl/notif_merge.sv
module notif_merge
    import notif_pkg::*;
#(
    parameter int VEC_W = 73
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  win_phase_e            phase,
    input  logic [3:0][VEC_W-1:0] nb_in,
    input  logic [VEC_W-1:0]      local_vec,
    output logic [VEC_W-1:0]      merged,
    output logic                  fin_stop,
    output logic                  win_valid,
    output logic [VEC_W-2:0]      win_vec
);
    localparam int DATA_W = VEC_W - 1;

    typedef struct packed {
        logic [NUM_PORTS-1:0][VEC_W-1:0] lat;
        logic [VEC_W-1:0]                acc;
        logic                            wv;
        logic [DATA_W-1:0]               wvec;
    } mrg_t;

    mrg_t mrg_d, mrg_q;
    logic [VEC_W-1:0] fin;

    always_comb begin
        merged = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            merged = merged | mrg_q.lat[p];
        end
        fin      = mrg_q.acc | merged;
        fin_stop = fin[VEC_W-1];

        mrg_d    = mrg_q;
        mrg_d.wv = 1'b0;
        if (phase == PH_LAST) begin
            for (int p = 0; p < 4; p++) begin
                mrg_d.lat[p] = '0;
            end
            mrg_d.lat[P_LOCAL] = local_vec;
            mrg_d.acc          = '0;
            mrg_d.wv           = !fin_stop;
            if (!fin_stop) begin
                mrg_d.wvec = fin[DATA_W-1:0];
            end
        end else begin
            for (int p = 0; p < 4; p++) begin
                mrg_d.lat[p] = nb_in[p];
            end
            mrg_d.lat[P_LOCAL] = '0;
            mrg_d.acc          = fin;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mrg_q <= '0;
        end else begin
            mrg_q <= mrg_d;
        end
    end

    assign win_valid = mrg_q.wv;
    assign win_vec   = mrg_q.wvec;

    AST_ONE_CYCLE_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_FIRST) |-> (merged == $past(nb_in[0] | nb_in[1] | nb_in[2] | nb_in[3]))); // R2

    AST_LOCAL_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_FIRST) |-> (mrg_q.lat[P_LOCAL] == '0)); // R4

    AST_DELIVER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |=> !win_valid); // R1

    AST_STOP_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LAST && fin_stop) |=> !win_valid); // R8

endmodule

// File: rtl/notif_sender.sv
module notif_sender
    import notif_pkg::*;
#(
    parameter int N_CORES  = 36,
    parameter int FIELD_W  = 2,
    parameter int PEND_MAX = 4,
    parameter int NODE_ID  = 0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  win_phase_e                   phase,
    input  logic                         fin_stop,
    input  logic                         req_valid,
    input  logic                         tracker_full,
    output logic                         req_ready,
    output logic [N_CORES*FIELD_W:0]     local_vec
);
    localparam int PEND_W = $clog2(PEND_MAX + 1);
    localparam int FMAX   = (1 << FIELD_W) - 1;
    localparam int STOP_B = N_CORES * FIELD_W;

    typedef struct packed {
        logic [PEND_W-1:0]  pend;
        logic [FIELD_W-1:0] inj;
    } snd_t;

    snd_t snd_d, snd_q;
    logic [PEND_W-1:0]  sent;
    logic [PEND_W-1:0]  after;
    logic [FIELD_W-1:0] next_inj;
    logic               accept;

    always_comb begin
        snd_d = snd_q;
        sent  = '0;
        if (phase == PH_LAST && !fin_stop) begin
            sent = PEND_W'(snd_q.inj);
        end
        after     = snd_q.pend - sent;
        next_inj  = (int'(after) > FMAX) ? FIELD_W'(FMAX) : FIELD_W'(after);
        req_ready = (snd_q.pend < PEND_W'(PEND_MAX));
        accept    = req_valid && req_ready;

        snd_d.pend = after + PEND_W'(accept);
        if (phase == PH_LAST) begin
            snd_d.inj = next_inj;
        end

        local_vec = '0;
        local_vec[NODE_ID*FIELD_W +: FIELD_W] = next_inj;
        local_vec[STOP_B] = tracker_full;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snd_q <= '0;
        end else begin
            snd_q <= snd_d;
        end
    end

    AST_PEND_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        snd_q.pend <= PEND_W'(PEND_MAX)); // R6

    AST_INJ_WITHIN_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        PEND_W'(snd_q.inj) <= snd_q.pend); // R7

    AST_STOP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LAST && fin_stop) |=> (snd_q.pend >= $past(snd_q.pend))); // R8

endmodule

// File: rtl/notif_node.sv
module notif_node
    import notif_pkg::*;
#(
    parameter int N_CORES  = 36,
    parameter int FIELD_W  = 2,
    parameter int WINDOW   = 13,
    parameter int PEND_MAX = 4,
    parameter int NODE_ID  = 0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_CORES*FIELD_W:0]   in_north,
    input  logic [N_CORES*FIELD_W:0]   in_east,
    input  logic [N_CORES*FIELD_W:0]   in_south,
    input  logic [N_CORES*FIELD_W:0]   in_west,
    output logic [N_CORES*FIELD_W:0]   out_north,
    output logic [N_CORES*FIELD_W:0]   out_east,
    output logic [N_CORES*FIELD_W:0]   out_south,
    output logic [N_CORES*FIELD_W:0]   out_west,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic                       tracker_full,
    output logic                       win_valid,
    output logic [N_CORES*FIELD_W-1:0] win_vec
);
    localparam int VEC_W = N_CORES * FIELD_W + 1;

    win_phase_e            phase;
    logic [3:0][VEC_W-1:0] nb_in;
    logic [VEC_W-1:0]      local_vec;
    logic [VEC_W-1:0]      merged;
    logic                  fin_stop;

    assign nb_in[P_NORTH] = in_north;
    assign nb_in[P_EAST]  = in_east;
    assign nb_in[P_SOUTH] = in_south;
    assign nb_in[P_WEST]  = in_west;

    notif_window_timer #(
        .WINDOW (WINDOW)
    ) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    notif_sender #(
        .N_CORES  (N_CORES),
        .FIELD_W  (FIELD_W),
        .PEND_MAX (PEND_MAX),
        .NODE_ID  (NODE_ID)
    ) i_sender (
        .clk          (clk),
        .rst_n        (rst_n),
        .phase        (phase),
        .fin_stop     (fin_stop),
        .req_valid    (req_valid),
        .tracker_full (tracker_full),
        .req_ready    (req_ready),
        .local_vec    (local_vec)
    );

    notif_merge #(
        .VEC_W (VEC_W)
    ) i_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .nb_in     (nb_in),
        .local_vec (local_vec),
        .merged    (merged),
        .fin_stop  (fin_stop),
        .win_valid (win_valid),
        .win_vec   (win_vec)
    );

    assign out_north = merged;
    assign out_east  = merged;
    assign out_south = merged;
    assign out_west  = merged;

    initial begin
        assert (NODE_ID >= 0 && NODE_ID < N_CORES) else $error("node id out of range");
    end

endmodule

// File: tb/test_notif_node.sv
module test_notif_node;
    localparam int NC   = 36;
    localparam int FW   = 2;
    localparam int WIN  = 13;
    localparam int PMAX = 4;
    localparam int DIM  = 6;
    localparam int VW   = NC * FW + 1;
    localparam int DW   = NC * FW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [VW-1:0] on_n [NC];
    logic [VW-1:0] on_e [NC];
    logic [VW-1:0] on_s [NC];
    logic [VW-1:0] on_w [NC];
    logic [VW-1:0] in_n [NC];
    logic [VW-1:0] in_e [NC];
    logic [VW-1:0] in_s [NC];
    logic [VW-1:0] in_w [NC];
    logic          req_v [NC];
    logic          tfull [NC];
    logic          rdy   [NC];
    logic          wv    [NC];
    logic [DW-1:0] wvec  [NC];

    for (genvar i = 0; i < NC; i++) begin : g_mesh
        localparam int X = i % DIM;
        localparam int Y = i / DIM;
        if (Y > 0)       begin : g_n assign in_n[i] = on_s[i-DIM]; end else begin : g_nz assign in_n[i] = '0; end
        if (Y < DIM - 1) begin : g_s assign in_s[i] = on_n[i+DIM]; end else begin : g_sz assign in_s[i] = '0; end
        if (X > 0)       begin : g_w assign in_w[i] = on_e[i-1];   end else begin : g_wz assign in_w[i] = '0; end
        if (X < DIM - 1) begin : g_e assign in_e[i] = on_w[i+1];   end else begin : g_ez assign in_e[i] = '0; end

        notif_node #(
            .N_CORES (NC), .FIELD_W (FW), .WINDOW (WIN), .PEND_MAX (PMAX), .NODE_ID (i)
        ) i_notif_node (
            .clk (clk), .rst_n (rst_n),
            .in_north (in_n[i]), .in_east (in_e[i]), .in_south (in_s[i]), .in_west (in_w[i]),
            .out_north (on_n[i]), .out_east (on_e[i]), .out_south (on_s[i]), .out_west (on_w[i]),
            .req_valid (req_v[i]), .req_ready (rdy[i]), .tracker_full (tfull[i]),
            .win_valid (wv[i]), .win_vec (wvec[i])
        );
    end

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    int pend [NC];
    int inj  [NC];
    bit sinj [NC];
    int mcnt = 0;
    bit ewv = 1'b0;
    logic [DW-1:0] evec = '0;
    logic [VW-1:0] prev_or14 = '0;
    int g = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input string act, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%s expected=%s (cycle %0d)", req, what, act, exp, g);
        end
    endtask

    function automatic logic [DW-1:0] model_vec();
        logic [DW-1:0] v = '0;
        for (int i = 0; i < NC; i++) v[i*FW +: FW] = FW'(inj[i]);
        return v;
    endfunction

    function automatic int sat(input int v);
        return (v > (1 << FW) - 1) ? (1 << FW) - 1 : v;
    endfunction

    task automatic check_all();
        logic [VW-1:0] exp14;
        for (int i = 0; i < NC; i++) begin
            check(rdy[i] == (pend[i] < PMAX), "R6 R10", $sformatf("ready node %0d", i),
                  $sformatf("%0b", rdy[i]), $sformatf("%0b", pend[i] < PMAX));
            check(wv[i] == ewv, "R1 R8", $sformatf("win_valid node %0d", i),
                  $sformatf("%0b", wv[i]), $sformatf("%0b", ewv));
            if (ewv)
                check(wvec[i] == evec, "R3 R5 R7", $sformatf("win_vec node %0d", i),
                      $sformatf("%h", wvec[i]), $sformatf("%h", evec));
            check(on_n[i] == on_e[i] && on_e[i] == on_s[i] && on_s[i] == on_w[i], "R2",
                  $sformatf("outputs equal node %0d", i), $sformatf("%h", on_e[i]), $sformatf("%h", on_n[i]));
        end
        if (mcnt == 0) begin
            exp14 = '0;
            exp14[14*FW +: FW] = FW'(inj[14]);
            exp14[VW-1] = sinj[14];
        end else begin
            exp14 = prev_or14;
        end
        check(on_n[14] == exp14, "R2 R4", "node 14 merge", $sformatf("%h", on_n[14]), $sformatf("%h", exp14));
        prev_or14 = on_s[8] | on_n[20] | on_e[13] | on_w[15];
    endtask

    task automatic model_update();
        bit stopped;
        int sent, after;
        if (mcnt == WIN - 1) begin
            stopped = 1'b0;
            for (int i = 0; i < NC; i++) stopped |= sinj[i];
            ewv = !stopped;
            if (!stopped) evec = model_vec();
            for (int i = 0; i < NC; i++) begin
                sent  = stopped ? 0 : inj[i];
                after = pend[i] - sent;
                inj[i]  = sat(after);
                pend[i] = after + ((req_v[i] && pend[i] < PMAX) ? 1 : 0);
                sinj[i] = tfull[i];
            end
            mcnt = 0;
        end else begin
            ewv = 1'b0;
            for (int i = 0; i < NC; i++)
                if (req_v[i] && pend[i] < PMAX) pend[i]++;
            mcnt++;
        end
    endtask

    task automatic drive();
        for (int i = 0; i < NC; i++) begin
            req_v[i] = 1'b0;
            tfull[i] = 1'b0;
        end
        if (g < 40) begin
            if (g == 0) req_v[0] = 1'b1;
            if (g >= 1 && g <= 5) req_v[7] = 1'b1;   // R6: fifth request refused
            if (g == 25) tfull[20] = 1'b1;            // R8: stop in window 2
        end else begin
            for (int i = 0; i < NC; i++) begin
                req_v[i] = ($urandom % 3) == 0;
                tfull[i] = ($urandom % 400) == 0;
            end
        end
    endtask

    task automatic directed();
        if (g == 0)
            for (int i = 0; i < NC; i++) begin
                check(on_n[i] == '0 && rdy[i] && !wv[i], "R9", $sformatf("reset node %0d", i),
                      $sformatf("%h/%0b/%0b", on_n[i], rdy[i], wv[i]), "0/1/0");
            end
        if (g == 12)
            check(on_e[0][1:0] == 2'd0, "R4", "no local field before window start",
                  $sformatf("%0d", on_e[0][1:0]), "0");
        if (g == 13)
            check(on_e[0][1:0] == 2'd1, "R4", "local field in first window cycle",
                  $sformatf("%0d", on_e[0][1:0]), "1");
        if (g == 22)
            check(on_w[35][1:0] == 2'd0, "R3", "far corner before 10 hops",
                  $sformatf("%0d", on_w[35][1:0]), "0");
        if (g == 23)
            check(on_w[35][1:0] == 2'd1, "R3", "far corner at 10 hops",
                  $sformatf("%0d", on_w[35][1:0]), "1");
        if (g == 26)
            check(wvec[35][15:14] == 2'd3, "R7", "saturated field of node 7",
                  $sformatf("%0d", wvec[35][15:14]), "3");
        if (g == 39)
            check(!wv[0], "R8", "stopped window not delivered", $sformatf("%0b", wv[0]), "0");
        if (g == 52)
            check(wv[0] && wvec[0][15:14] == 2'd1, "R8 R10", "resend after stop",
                  $sformatf("%0b/%0d", wv[0], wvec[0][15:14]), "1/1");
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NC; i++) begin
            pend[i] = 0; inj[i] = 0; sinj[i] = 1'b0;
            req_v[i] = 1'b0; tfull[i] = 1'b0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        while (g < WIN * 90) begin
            check_all();
            directed();
            drive();
            model_update();
            @(negedge clk);
            g++;
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule